// File: doc/BRIEF.md
# Two-Wide Instruction Fetch with In-Fetch Branch Resolution

This block is the front end of a small in-order-fetch pipeline. Every cycle it reads up to two consecutive instruction words at the program counter. It pushes ordinary instructions into a downstream pre-issue queue, one or two at a time. Conditional branches, jumps and the halt word never reach that queue. Branches and jumps are resolved here, in the same cycle they are fetched. When their operands are ready, the program counter moves to the target with no lost cycle.

When a branch's source registers are still being produced, fetch freezes on the branch. It re-evaluates the branch every cycle against the scoreboard's ready flags, and it resumes once the branch resolves. The block uses the queue's free-slot count, as the queue registered it in the previous cycle, to decide how many words it may take. A jump-and-link also produces a write of its return address for the register file.

Top module: `dual_fetch_unit`

## Requirements
- R1: After a synchronous active-low reset, the program counter equals START_PC, the stall and halt flags are low, and nothing is enqueued.
- R2: With two or more free queue slots and two ordinary words, the word at PC goes out on enqueue port 0 and the word at PC+4 on port 1 in the same cycle, and the PC advances by 8.
- R3: With zero free slots nothing is fetched and the PC holds. With one free slot, only the word at PC is taken and the PC advances by 4.
- R4: Opcode 1100011 with funct3 000 branches if the two registers are equal, and with funct3 001 if they differ. The registers are read at bits 19:15 and 24:20. When both ready flags are set, the next PC is the branch address plus the sign-extended B-format immediate if taken, else the branch address plus 4.
- R5: Opcode 1101111 is a jump: the next PC is its address plus the sign-extended J-format immediate, and it never waits. It raises a link write of its address plus 4 to the register at bits 11:7, unless that register is 0.
- R6: A branch whose source ready flags are not both set raises the stall flag and holds the PC at the branch. Nothing is enqueued while the stall flag is set.
- R7: While stalled, the branch resolves in the first cycle its flags are both set, even with zero free slots. The stall flag then drops, and normal fetch resumes at the resolved PC the next cycle.
- R8: A branch or jump in the first slot discards the second word: neither port enqueues.
- R9: A branch in the second slot lets the first word enqueue. It resolves with PC+4 as its address, and if it must wait, the PC becomes PC+4.
- R10: No branch, jump or halt word ever appears with an enqueue strobe.
- R11: The word 0x00100073 is a halt. It is not enqueued, the PC is left at its address, and fetch stops for good. A halt in the second slot still lets the first word enqueue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_slots_i | input | FREE_W | Free pre-issue entries, registered by the queue |
| reg_ready_i | input | 32 | Per-register ready flags from the scoreboard |
| rd_addr_a_o | output | 5 | First register read address (branch rs1) |
| rd_addr_b_o | output | 5 | Second register read address (branch rs2) |
| rd_data_a_i | input | 32 | Read data for address A |
| rd_data_b_i | input | 32 | Read data for address B |
| pc_o | output | 32 | Program counter, fetch address |
| imem_word0_i | input | 32 | Instruction word at pc_o |
| imem_word1_i | input | 32 | Instruction word at pc_o+4 |
| enq0_valid_o | output | 1 | Enqueue strobe, first slot |
| enq0_instr_o | output | 32 | Instruction word, first slot |
| enq1_valid_o | output | 1 | Enqueue strobe, second slot |
| enq1_instr_o | output | 32 | Instruction word, second slot |
| link_we_o | output | 1 | Return-address write strobe |
| link_rd_o | output | 5 | Return-address destination register |
| link_data_o | output | 32 | Return address |
| stall_o | output | 1 | Fetch frozen on an unresolved branch |
| halted_o | output | 1 | Fetch stopped by a halt word |

## Verification
Some rules are checked on every cycle. These are: in-order strobes, the enqueue count never exceeding the free count, no control word entering the queue, no enqueue during a stall or after a halt, the PC held through consecutive stall cycles, and halt never clearing. Other behaviour only the directed scenarios can show. This covers target arithmetic for both branch senses and the jump, the return-address value, and discard of the second slot. It also covers resolution in a zero-free-slot cycle and the PC value after a second-slot stall.

// File: rtl/fetch_pkg.sv
// Package: shared types and the per-word decode for the two-wide fetch unit.
// Assumes 32-bit instruction words and a 32-entry register file.
package fetch_pkg;
    localparam int ILEN = 32;
    localparam int RA_W = 5;
    localparam int NREG = 1 << RA_W;

    localparam logic [6:0]      OPC_BRANCH = 7'b1100011;
    localparam logic [6:0]      OPC_JUMP   = 7'b1101111;
    localparam logic [2:0]      F3_EQ      = 3'b000;
    localparam logic [2:0]      F3_NE      = 3'b001;
    localparam logic [ILEN-1:0] HALT_WORD  = 32'h0010_0073;

    typedef enum logic [2:0] {
        K_PLAIN,
        K_BR_EQ,
        K_BR_NE,
        K_JUMP,
        K_HALT
    } kind_t;

    typedef struct packed {
        kind_t            kind;
        logic [RA_W-1:0]  rs1;
        logic [RA_W-1:0]  rs2;
        logic [RA_W-1:0]  rd;
        logic [ILEN-1:0]  imm;
    } slot_info_t;
endpackage

// File: rtl/fetch_slot_decode.sv
// Module: classifies one fetched word and extracts the fields that fetch needs.
// Assumes: any word that is not a recognised branch, jump or halt is plain.
module fetch_slot_decode
    import fetch_pkg::*;
(
    input  logic [ILEN-1:0] word_i,
    output slot_info_t      info_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    assign opc = word_i[6:0];
    assign f3  = word_i[14:12];

    // Classify the word and pick the immediate format that matches its kind.
    always_comb begin
        info_o.rs1 = word_i[19:15];
        info_o.rs2 = word_i[24:20];
        info_o.rd  = word_i[11:7];
        info_o.kind = K_PLAIN;
        info_o.imm  = '0;
        if (word_i == HALT_WORD) begin
            info_o.kind = K_HALT;
        end else if (opc == OPC_BRANCH && f3 == F3_EQ) begin
            info_o.kind = K_BR_EQ;
        end else if (opc == OPC_BRANCH && f3 == F3_NE) begin
            info_o.kind = K_BR_NE;
        end else if (opc == OPC_JUMP) begin
            info_o.kind = K_JUMP;
        end
        if (info_o.kind == K_JUMP) begin
            info_o.imm = {{11{word_i[31]}}, word_i[31], word_i[19:12],
                          word_i[20], word_i[30:21], 1'b0};
        end else begin
            info_o.imm = {{19{word_i[31]}}, word_i[31], word_i[7],
                          word_i[30:25], word_i[11:8], 1'b0};
        end
    end
endmodule

// File: rtl/fetch_branch_resolve.sv
// Module: decides readiness, direction and next PC for one branch or jump.
// Assumes the caller only acts on the outputs when the slot holds a control word.
module fetch_branch_resolve
    import fetch_pkg::*;
(
    input  slot_info_t      info_i,
    input  logic [ILEN-1:0] base_pc_i,
    input  logic [NREG-1:0] ready_i,
    input  logic [ILEN-1:0] src_a_i,
    input  logic [ILEN-1:0] src_b_i,
    output logic            ready_o,
    output logic [ILEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [RA_W-1:0] link_rd_o,
    output logic [ILEN-1:0] link_val_o
);
    logic            is_jump;
    logic            taken;
    logic [ILEN-1:0] target;
    logic [ILEN-1:0] fall;

    assign is_jump = (info_i.kind == K_JUMP);
    assign target  = base_pc_i + info_i.imm;
    assign fall    = base_pc_i + ILEN'(4);

    // Evaluate operand readiness and the branch direction.
    always_comb begin
        ready_o = is_jump || (ready_i[info_i.rs1] && ready_i[info_i.rs2]);
        if (is_jump) begin
            taken = 1'b1;
        end else if (info_i.kind == K_BR_NE) begin
            taken = (src_a_i != src_b_i);
        end else begin
            taken = (src_a_i == src_b_i);
        end
    end

    assign next_pc_o  = taken ? target : fall;
    assign link_we_o  = is_jump && (info_i.rd != '0);
    assign link_rd_o  = info_i.rd;
    assign link_val_o = fall;
endmodule

// File: rtl/dual_fetch_unit.sv
// Module: two-wide fetch that enqueues plain words and resolves control in fetch.
// Assumes imem words arrive combinationally for pc_o and pc_o+4, and that
// free_slots_i is the queue's registered count from the previous cycle.
module dual_fetch_unit
    import fetch_pkg::*;
#(
    parameter logic [31:0] START_PC = 32'h0000_0000,
    parameter int          FREE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_slots_i,
    input  logic [NREG-1:0]   reg_ready_i,
    output logic [RA_W-1:0]   rd_addr_a_o,
    output logic [RA_W-1:0]   rd_addr_b_o,
    input  logic [ILEN-1:0]   rd_data_a_i,
    input  logic [ILEN-1:0]   rd_data_b_i,
    output logic [ILEN-1:0]   pc_o,
    input  logic [ILEN-1:0]   imem_word0_i,
    input  logic [ILEN-1:0]   imem_word1_i,
    output logic              enq0_valid_o,
    output logic [ILEN-1:0]   enq0_instr_o,
    output logic              enq1_valid_o,
    output logic [ILEN-1:0]   enq1_instr_o,
    output logic              link_we_o,
    output logic [RA_W-1:0]   link_rd_o,
    output logic [ILEN-1:0]   link_data_o,
    output logic              stall_o,
    output logic              halted_o
);
    localparam int NSLOT = 2;

    logic [ILEN-1:0] words [NSLOT];
    slot_info_t      infos [NSLOT];

    logic [ILEN-1:0] pc_q, pc_d;
    logic            stall_q, stall_d;
    logic            halt_q, halt_d;

    logic            use_res, res_sel;
    slot_info_t      res_info;
    logic [ILEN-1:0] res_base;
    logic            res_ready;
    logic [ILEN-1:0] res_next;
    logic            res_link_we;
    logic            two_free;

    assign words[0] = imem_word0_i;
    assign words[1] = imem_word1_i;

    // One decoder per fetch slot.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            fetch_slot_decode u_dec (
                .word_i (words[s]),
                .info_o (infos[s])
            );
        end
    endgenerate

    // Steer the single resolver to whichever slot holds the control word.
    assign res_info = res_sel ? infos[1] : infos[0];
    assign res_base = res_sel ? (pc_q + ILEN'(4)) : pc_q;

    fetch_branch_resolve u_res (
        .info_i     (res_info),
        .base_pc_i  (res_base),
        .ready_i    (reg_ready_i),
        .src_a_i    (rd_data_a_i),
        .src_b_i    (rd_data_b_i),
        .ready_o    (res_ready),
        .next_pc_o  (res_next),
        .link_we_o  (res_link_we),
        .link_rd_o  (link_rd_o),
        .link_val_o (link_data_o)
    );

    assign two_free = (free_slots_i >= FREE_W'(2));

    // Choose what to enqueue, whether to resolve, and the next fetch state.
    always_comb begin
        enq0_valid_o = 1'b0;
        enq1_valid_o = 1'b0;
        use_res      = 1'b0;
        res_sel      = 1'b0;
        pc_d         = pc_q;
        stall_d      = stall_q;
        halt_d       = halt_q;
        if (!halt_q) begin
            if (stall_q) begin
                use_res = 1'b1;
            end else if (free_slots_i != '0) begin
                case (infos[0].kind)
                    K_HALT: halt_d = 1'b1;
                    K_BR_EQ, K_BR_NE, K_JUMP: use_res = 1'b1;
                    default: begin
                        enq0_valid_o = 1'b1;
                        pc_d = pc_q + ILEN'(4);
                        if (two_free) begin
                            case (infos[1].kind)
                                K_HALT: halt_d = 1'b1;
                                K_BR_EQ, K_BR_NE, K_JUMP: begin
                                    use_res = 1'b1;
                                    res_sel = 1'b1;
                                end
                                default: begin
                                    enq1_valid_o = 1'b1;
                                    pc_d = pc_q + ILEN'(8);
                                end
                            endcase
                        end
                    end
                endcase
            end
            if (use_res) begin
                if (res_ready) begin
                    pc_d    = res_next;
                    stall_d = 1'b0;
                end else begin
                    pc_d    = res_base;
                    stall_d = 1'b1;
                end
            end
        end
    end

    // Fetch state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= START_PC;
            stall_q <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            stall_q <= stall_d;
            halt_q  <= halt_d;
        end
    end

    assign pc_o         = pc_q;
    assign stall_o      = stall_q;
    assign halted_o     = halt_q;
    assign enq0_instr_o = imem_word0_i;
    assign enq1_instr_o = imem_word1_i;
    assign rd_addr_a_o  = res_info.rs1;
    assign rd_addr_b_o  = res_info.rs2;
    assign link_we_o    = use_res && res_ready && res_link_we;
endmodule

// File: rtl/dual_fetch_unit_chk.sv
// Checker: cycle-by-cycle rules at the ports of dual_fetch_unit.
// Assumes it is attached by the bind below; it only observes.
module dual_fetch_unit_chk #(
    parameter int FREE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FREE_W-1:0] free_slots_i,
    input logic [31:0]       pc_o,
    input logic              enq0_valid_o,
    input logic [31:0]       enq0_instr_o,
    input logic              enq1_valid_o,
    input logic [31:0]       enq1_instr_o,
    input logic              stall_o,
    input logic              halted_o
);
    a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        enq1_valid_o |-> enq0_valid_o);

    a_r3_within_free: assert property (@(posedge clk) disable iff (!rst_n)
        32'($countones({enq1_valid_o, enq0_valid_o})) <= 32'(free_slots_i));

    a_r6_no_enq_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (!enq0_valid_o && !enq1_valid_o));

    a_r6_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (!stall_o || $stable(pc_o)));

    a_r10_no_ctrl_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        enq0_valid_o |-> (enq0_instr_o[6:0] != 7'b1100011 &&
                          enq0_instr_o[6:0] != 7'b1101111 &&
                          enq0_instr_o != 32'h0010_0073));

    a_r10_no_ctrl_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        enq1_valid_o |-> (enq1_instr_o[6:0] != 7'b1100011 &&
                          enq1_instr_o[6:0] != 7'b1101111 &&
                          enq1_instr_o != 32'h0010_0073));

    a_r11_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    a_r11_no_enq_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !enq0_valid_o);
endmodule

bind dual_fetch_unit dual_fetch_unit_chk #(.FREE_W(FREE_W)) u_chk (.*);

// File: tb/dual_fetch_unit_bench.sv
// Bench: directed scenarios, one task each, with a behavioural memory and register file.
module dual_fetch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FREE_W     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FREE_W-1:0] free_slots = '0;
    logic [31:0]       ready = '1;
    logic [4:0]        ra, rb;
    logic [31:0]       da, db;
    logic [31:0]       pc, w0, w1;
    logic              e0, e1, lwe, stl, hlt;
    logic [31:0]       i0, i1, ldata;
    logic [4:0]        lrd;

    logic [31:0] mem [0:63];
    logic [31:0] rf  [0:31];
    logic [5:0]  idx0, idx1;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign idx0 = pc[7:2];
    assign idx1 = pc[7:2] + 6'd1;
    assign w0   = mem[idx0];
    assign w1   = mem[idx1];
    assign da   = rf[ra];
    assign db   = rf[rb];

    dual_fetch_unit #(.START_PC(32'h0), .FREE_W(FREE_W)) u_dual_fetch_unit (
        .clk(clk), .rst_n(rst_n), .free_slots_i(free_slots), .reg_ready_i(ready),
        .rd_addr_a_o(ra), .rd_addr_b_o(rb), .rd_data_a_i(da), .rd_data_b_i(db),
        .pc_o(pc), .imem_word0_i(w0), .imem_word1_i(w1),
        .enq0_valid_o(e0), .enq0_instr_o(i0), .enq1_valid_o(e1), .enq1_instr_o(i1),
        .link_we_o(lwe), .link_rd_o(lrd), .link_data_o(ldata),
        .stall_o(stl), .halted_o(hlt)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_b(logic [2:0] f3, logic [4:0] s1, logic [4:0] s2, int imm);
        logic [12:0] i = imm[12:0];
        return {i[12], i[10:5], s2, s1, f3, i[4:1], i[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(logic [4:0] rd, int imm);
        logic [20:0] i = imm[20:0];
        return {i[20], i[10:1], i[11], i[19:12], rd, 7'b1101111};
    endfunction

    // Fill memory with distinct plain words, set registers, reset the unit.
    task automatic setup();
        for (int k = 0; k < 64; k++) mem[k] = (32'(k) << 15) | 32'h0000_0033;
        for (int k = 0; k < 32; k++) rf[k] = 32'(k);
        ready = '1;
        @(negedge clk);
        rst_n = 1'b0;
        free_slots = 3'd4;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic edge_then();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        setup();
        free_slots = 3'd0;
        #1;
        check("R1 pc", pc, 32'h0);
        check("R1 stall", 32'(stl), 0);
        check("R1 halt", 32'(hlt), 0);
        check("R1 enq", 32'({e1, e0}), 0);
    endtask

    task automatic t_dual();
        setup();
        #1;
        check("R2 enq0", {31'b0, e0}, 1); check("R2 w0", i0, mem[0]);
        check("R2 enq1", {31'b0, e1}, 1); check("R2 w1", i1, mem[1]);
        edge_then(); check("R2 pc", pc, 32'd8);
        @(negedge clk); #1;
        check("R2 w2", i0, mem[2]); check("R2 w3", i1, mem[3]);
        edge_then(); check("R2 pc2", pc, 32'd16);
    endtask

    task automatic t_slots();
        setup();
        free_slots = 3'd0; #1;
        check("R3 none", 32'({e1, e0}), 0);
        edge_then(); check("R3 hold", pc, 32'd0);
        @(negedge clk); free_slots = 3'd1; #1;
        check("R3 one", 32'({e1, e0}), 1); check("R3 word", i0, mem[0]);
        edge_then(); check("R3 pc4", pc, 32'd4);
    endtask

    task automatic t_branch_slot0();
        setup();
        mem[0] = enc_b(3'b000, 5'd1, 5'd1, 16); #1;
        check("R8 discard", 32'({e1, e0}), 0);
        edge_then(); check("R4 beq taken", pc, 32'd16);
        check("R4 no stall", 32'(stl), 0);
        setup();
        mem[0] = enc_b(3'b001, 5'd3, 5'd3, 16); #1;
        edge_then(); check("R4 bne not taken", pc, 32'd4);
        setup();
        mem[0] = enc_b(3'b001, 5'd3, 5'd4, -0); mem[0] = enc_b(3'b001, 5'd3, 5'd4, 40); #1;
        edge_then(); check("R4 bne taken", pc, 32'd40);
    endtask

    task automatic t_branch_slot1();
        setup();
        mem[1] = enc_b(3'b000, 5'd1, 5'd3, 12); #1;
        check("R9 slot0 enq", 32'({e1, e0}), 1); check("R10 br not enq", 32'(e1), 0);
        edge_then(); check("R9 not taken", pc, 32'd8);
        setup();
        mem[1] = enc_b(3'b000, 5'd2, 5'd2, -4); #1;
        edge_then(); check("R9 taken back", pc, 32'd0);
    endtask

    task automatic t_jump();
        setup();
        mem[1] = enc_j(5'd5, 8); #1;
        check("R5 link we", 32'(lwe), 1); check("R5 link rd", 32'(lrd), 5);
        check("R5 link data", ldata, 32'd8);
        edge_then(); check("R5 target", pc, 32'd12);
        setup();
        mem[0] = enc_j(5'd0, 20); ready = '0; #1;
        check("R5 x0 no link", 32'(lwe), 0); check("R8 jump discard", 32'({e1, e0}), 0);
        edge_then(); check("R5 no wait", pc, 32'd20);
    endtask

    task automatic t_stall();
        setup();
        mem[0] = enc_b(3'b000, 5'd1, 5'd2, 24); rf[2] = 32'd1;
        ready[2] = 1'b0; #1;
        check("R6 no enq", 32'({e1, e0}), 0);
        edge_then(); check("R6 stall", 32'(stl), 1); check("R6 pc held", pc, 32'd0);
        @(negedge clk); free_slots = 3'd0; #1;
        edge_then(); check("R6 still", 32'(stl), 1); check("R6 pc still", pc, 32'd0);
        @(negedge clk); ready = '1; #1;
        check("R7 no enq", 32'({e1, e0}), 0);
        edge_then(); check("R7 resolved", 32'(stl), 0); check("R7 target", pc, 32'd24);
        @(negedge clk); free_slots = 3'd4; #1;
        check("R7 resume", i0, mem[6]); check("R7 resume2", 32'({e1, e0}), 3);
        edge_then(); check("R7 pc", pc, 32'd32);
    endtask

    task automatic t_stall_slot1();
        setup();
        mem[1] = enc_b(3'b001, 5'd3, 5'd4, 8); ready[4] = 1'b0; #1;
        check("R9 first enq", 32'({e1, e0}), 1);
        edge_then(); check("R9 pc at br", pc, 32'd4); check("R9 stall", 32'(stl), 1);
        @(negedge clk); ready = '1; #1;
        edge_then(); check("R7 slot1 target", pc, 32'd12);
    endtask

    task automatic t_halt();
        setup();
        mem[1] = 32'h0010_0073; #1;
        check("R11 first enq", 32'({e1, e0}), 1);
        edge_then(); check("R11 halted", 32'(hlt), 1); check("R11 pc", pc, 32'd4);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            check("R11 no enq", 32'({e1, e0}), 0);
        end
        edge_then(); check("R11 pc stays", pc, 32'd4); check("R11 still", 32'(hlt), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_dual();
        t_slots();
        t_branch_slot0();
        t_branch_slot1();
        t_jump();
        t_stall();
        t_stall_slot1();
        t_halt();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule